// File: doc/BRIEF.md
# Fractional Events-per-Cycle Scheduler

This block paces an audio stream onto an 8 kHz isochronous bus. On every bus-cycle strobe it works out how many audio events (one sample per channel) belong in the next packet. The ratio of sample rate to cycle rate is rarely a whole number, so the block keeps an exact rational leftover with denominator 8000. The whole part of that leftover is released as events and the fractional part is carried into the next cycle. A 44.1 kHz stream therefore averages 5 41/80 events per cycle, sent as a mix of 5- and 6-event packets.

Two transmission modes are supported. Free-running mode sends every whole event that has accumulated. Gated mode sends either exactly one timestamp interval of events or none. A packet goes out only when the sample store holds enough samples and a packet slot is free. Otherwise nothing is committed and the same decision is retried on the next strobe. For each packet the block reports the event count and the payload length in quadlets. It also reports the largest event count the current configuration can produce, so that the caller can size its packet slots.

Top module: `event_pacer`

## Requirements
- R1: After reset `pkt_valid`, `pkt_events` and `pkt_quadlets` are all zero.
- R2: At configuration the rate is split into a whole part (rate / 8000) and a numerator (rate mod 8000). In free-running mode (`cfg_gated`=0), `max_events` equals the whole part, plus one when the numerator is non-zero.
- R3: Each strobe forms a candidate equal to the leftover plus the split rate. A numerator reaching 8000 carries one into the whole part. In free-running mode the event count is the candidate's whole part, so 44.1 kHz yields 441 events over 80 committed cycles in a 5/6 pattern.
- R4: In gated mode (`cfg_gated`=1) the event count is `cfg_interval` when the candidate's whole part is at least `cfg_interval`, and zero otherwise. A zero-event packet is still committed.
- R5: On commit the leftover becomes the candidate minus the event count, with the numerator kept. The numerator always stays below 8000, and in free-running mode the whole part of the leftover is zero after a commit.
- R6: A packet is committed only when `slot_free` is 1 and `buf_level` (samples summed over all channels) is at least event count × `cfg_channels`. Otherwise `pkt_valid` stays 0 and the leftover is unchanged, so the retry sees the same candidate.
- R7: `pkt_quadlets` equals `pkt_events` × `cfg_channels` + 2 for every committed packet.
- R8: In gated mode `max_events` equals `cfg_interval`, and no committed count exceeds `max_events`.
- R9: `cfg_load` latches the configuration and clears the leftover to 0/8000. A strobe in the same cycle as `cfg_load` is dropped.
- R10: `pkt_valid` is a one-cycle strobe, raised only in the cycle after a `cycle_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Latch configuration and clear the leftover |
| cfg_rate | input | RATE_W | Sample rate in Hz |
| cfg_gated | input | 1 | 1 = gated (interval-or-nothing) mode, 0 = free-running mode |
| cfg_interval | input | IVL_W | Timestamp interval in events |
| cfg_channels | input | CH_W | Channels per event |
| cycle_tick | input | 1 | One strobe per bus cycle |
| buf_level | input | LVL_W | Samples held in the sample store |
| slot_free | input | 1 | A packet slot is available |
| pkt_valid | output | 1 | Packet committed this cycle |
| pkt_events | output | CNT_W | Events in the committed packet |
| pkt_quadlets | output | Q_W | Payload length in quadlets |
| max_events | output | CNT_W | Largest event count for the current configuration |

## Verification
Configuration and the cycle strobe can land in the same clock. The bench provokes this by raising `cfg_load` together with `cycle_tick` after a 44.1 kHz stream has already left a non-zero numerator behind. It judges the outcome in two steps: that cycle must produce no packet, and the following strobe must produce 5 events rather than the 6 that a surviving leftover would give. A second coincidence is a strobe arriving while the slot is busy or the store is one sample short. This is judged by the next free strobe repeating the same count instead of a doubled one.

// File: rtl/event_pacer_pkg.sv
package event_pacer_pkg;
   typedef enum logic {
      XMIT_FREE  = 1'b0,
      XMIT_GATED = 1'b1
   } xmit_mode_e;
endpackage

// File: rtl/pacer_rate_split.sv
module pacer_rate_split #(
   parameter int RATE_W = 18,
   parameter int DEN    = 8000,
   parameter int CNT_W  = 8,
   localparam int NUM_W = $clog2(DEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [RATE_W-1:0] rate,
   output logic [CNT_W-1:0]  whole,
   output logic [NUM_W-1:0]  numer
);
   logic [CNT_W-1:0] whole_d;
   logic [NUM_W-1:0] numer_d;

   generate
      if ((DEN & (DEN - 1)) == 0) begin : g_pow2
         assign whole_d = CNT_W'(rate >> NUM_W);
         assign numer_d = NUM_W'(rate & RATE_W'(DEN - 1));
      end else begin : g_divide
         assign whole_d = CNT_W'(rate / RATE_W'(DEN));
         assign numer_d = NUM_W'(rate % RATE_W'(DEN));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         whole <= '0;
         numer <= '0;
      end else if (load) begin
         whole <= whole_d;
         numer <= numer_d;
      end
   end

   assert_numer_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      numer < NUM_W'(DEN));
endmodule

// File: rtl/pacer_accum.sv
module pacer_accum #(
   parameter int DEN    = 8000,
   parameter int CNT_W  = 8,
   localparam int NUM_W = $clog2(DEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             commit,
   input  logic             free_mode,
   input  logic [CNT_W-1:0] spc_whole,
   input  logic [NUM_W-1:0] spc_numer,
   input  logic [CNT_W-1:0] take,
   output logic [CNT_W-1:0] cand_whole,
   output logic [NUM_W-1:0] cand_numer
);
   logic [CNT_W-1:0] left_whole;
   logic [NUM_W-1:0] left_numer;
   logic [NUM_W:0]   nsum;
   logic             carry;

   always_comb begin
      nsum       = {1'b0, left_numer} + {1'b0, spc_numer};
      carry      = nsum >= (NUM_W+1)'(DEN);
      cand_numer = carry ? NUM_W'(nsum - (NUM_W+1)'(DEN)) : NUM_W'(nsum);
      cand_whole = left_whole + spc_whole + CNT_W'(carry);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_whole <= '0;
         left_numer <= '0;
      end else if (clear) begin
         left_whole <= '0;
         left_numer <= '0;
      end else if (commit) begin
         left_whole <= cand_whole - take;
         left_numer <= cand_numer;
      end
   end

   assert_left_numer_R5: assert property (@(posedge clk) disable iff (!rst_n)
      left_numer < NUM_W'(DEN));
   assert_free_left_whole_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(commit && free_mode && !clear) |-> left_whole == '0);
   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clear) |-> (left_whole == '0 && left_numer == '0));
endmodule

// File: rtl/pacer_pick.sv
module pacer_pick #(
   parameter int CNT_W = 8,
   parameter int CH_W  = 4,
   parameter int IVL_W = 6,
   parameter int NUM_W = 13,
   localparam int Q_W  = CNT_W + CH_W + 1
) (
   input  logic             gated,
   input  logic [IVL_W-1:0] interval,
   input  logic [CH_W-1:0]  channels,
   input  logic [CNT_W-1:0] cand_whole,
   input  logic [CNT_W-1:0] spc_whole,
   input  logic [NUM_W-1:0] spc_numer,
   output logic [CNT_W-1:0] events,
   output logic [Q_W-1:0]   need,
   output logic [Q_W-1:0]   quadlets,
   output logic [CNT_W-1:0] max_ev
);
   logic [CNT_W-1:0] ivl_w;

   always_comb begin
      ivl_w = CNT_W'(interval);
      if (gated) begin
         events = (cand_whole >= ivl_w) ? ivl_w : '0;
         max_ev = ivl_w;
      end else begin
         events = cand_whole;
         max_ev = spc_whole + CNT_W'(spc_numer != '0);
      end
      need     = Q_W'(events) * Q_W'(channels);
      quadlets = need + Q_W'(2);
   end
endmodule

// File: rtl/event_pacer.sv
module event_pacer
   import event_pacer_pkg::*;
#(
   parameter int RATE_W = 18,
   parameter int DEN    = 8000,
   parameter int CNT_W  = 8,
   parameter int CH_W   = 4,
   parameter int IVL_W  = 6,
   parameter int LVL_W  = 12,
   localparam int NUM_W = $clog2(DEN),
   localparam int Q_W   = CNT_W + CH_W + 1,
   localparam int CMP_W = (LVL_W > Q_W) ? LVL_W : Q_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_load,
   input  logic [RATE_W-1:0] cfg_rate,
   input  logic              cfg_gated,
   input  logic [IVL_W-1:0]  cfg_interval,
   input  logic [CH_W-1:0]   cfg_channels,
   input  logic              cycle_tick,
   input  logic [LVL_W-1:0]  buf_level,
   input  logic              slot_free,
   output logic              pkt_valid,
   output logic [CNT_W-1:0]  pkt_events,
   output logic [Q_W-1:0]    pkt_quadlets,
   output logic [CNT_W-1:0]  max_events
);
   generate
      if (DEN < 2) begin : g_bad_den
         $error("DEN must be at least 2");
      end
      if (IVL_W > CNT_W) begin : g_bad_ivl
         $error("IVL_W must not exceed CNT_W");
      end
      if (RATE_W - NUM_W >= CNT_W) begin : g_bad_rate
         $error("CNT_W too narrow for the rate range");
      end
   endgenerate

   xmit_mode_e       mode_r;
   logic [IVL_W-1:0] ivl_r;
   logic [CH_W-1:0]  ch_r;
   logic [CNT_W-1:0] spc_whole, cand_whole, n_events;
   logic [NUM_W-1:0] spc_numer, cand_numer;
   logic [Q_W-1:0]   need, quad;
   logic             enough, commit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_r <= XMIT_FREE;
         ivl_r  <= '0;
         ch_r   <= '0;
      end else if (cfg_load) begin
         mode_r <= xmit_mode_e'(cfg_gated);
         ivl_r  <= cfg_interval;
         ch_r   <= cfg_channels;
      end
   end

   pacer_rate_split #(.RATE_W(RATE_W), .DEN(DEN), .CNT_W(CNT_W)) u_split (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cfg_load),
      .rate  (cfg_rate),
      .whole (spc_whole),
      .numer (spc_numer)
   );

   pacer_accum #(.DEN(DEN), .CNT_W(CNT_W)) u_accum (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (cfg_load),
      .commit     (commit),
      .free_mode  (mode_r == XMIT_FREE),
      .spc_whole  (spc_whole),
      .spc_numer  (spc_numer),
      .take       (n_events),
      .cand_whole (cand_whole),
      .cand_numer (cand_numer)
   );

   pacer_pick #(.CNT_W(CNT_W), .CH_W(CH_W), .IVL_W(IVL_W), .NUM_W(NUM_W)) u_pick (
      .gated      (mode_r == XMIT_GATED),
      .interval   (ivl_r),
      .channels   (ch_r),
      .cand_whole (cand_whole),
      .spc_whole  (spc_whole),
      .spc_numer  (spc_numer),
      .events     (n_events),
      .need       (need),
      .quadlets   (quad),
      .max_ev     (max_events)
   );

   assign enough = CMP_W'(buf_level) >= CMP_W'(need);
   assign commit = cycle_tick && !cfg_load && slot_free && enough;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pkt_valid    <= 1'b0;
         pkt_events   <= '0;
         pkt_quadlets <= '0;
      end else begin
         pkt_valid <= commit;
         if (commit) begin
            pkt_events   <= n_events;
            pkt_quadlets <= quad;
         end
      end
   end

   assert_valid_after_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> $past(cycle_tick));
   assert_no_slot_no_pkt_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!slot_free) |-> !pkt_valid);
   assert_cfg_drops_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_load) |-> !pkt_valid);
   assert_gated_all_or_none_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && mode_r == XMIT_GATED) |->
         (pkt_events == '0 || pkt_events == CNT_W'(ivl_r)));
   assert_within_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> pkt_events <= max_events);
endmodule

// File: tb/event_pacer_tb.sv
module event_pacer_tb;
   localparam int RATE_W = 18;
   localparam int CNT_W  = 8;
   localparam int CH_W   = 4;
   localparam int IVL_W  = 6;
   localparam int LVL_W  = 12;
   localparam int Q_W    = CNT_W + CH_W + 1;
   localparam int NVEC   = 7;
   localparam int NTICK  = 80;
   // rate, gated, interval, channels, expected total events, expected max_events
   localparam int VEC [NVEC][6] = '{
      '{ 44100, 0,  8, 2,  441,  6},
      '{ 48000, 0,  8, 2,  480,  6},
      '{ 32000, 0,  8, 1,  320,  4},
      '{ 88200, 0, 16, 2,  882, 12},
      '{ 44100, 1,  8, 2,  440,  8},
      '{ 96000, 1, 16, 2,  960, 16},
      '{192000, 1, 32, 8, 1920, 32}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_load = 1'b0;
   logic [RATE_W-1:0] cfg_rate = '0;
   logic              cfg_gated = 1'b0;
   logic [IVL_W-1:0]  cfg_interval = '0;
   logic [CH_W-1:0]   cfg_channels = '0;
   logic              cycle_tick = 1'b0;
   logic [LVL_W-1:0]  buf_level = '0;
   logic              slot_free = 1'b0;
   logic              pkt_valid;
   logic [CNT_W-1:0]  pkt_events;
   logic [Q_W-1:0]    pkt_quadlets;
   logic [CNT_W-1:0]  max_events;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int m_acc, m_rate, m_gated, m_ivl, m_ch;

   always #10 clk = ~clk;

   event_pacer u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_rate(cfg_rate),
      .cfg_gated(cfg_gated), .cfg_interval(cfg_interval), .cfg_channels(cfg_channels),
      .cycle_tick(cycle_tick), .buf_level(buf_level), .slot_free(slot_free),
      .pkt_valid(pkt_valid), .pkt_events(pkt_events), .pkt_quadlets(pkt_quadlets),
      .max_events(max_events)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic configure(input int rate, input int gated, input int ivl,
                            input int ch, input bit with_tick);
      @(negedge clk);
      cfg_load     = 1'b1;
      cfg_rate     = RATE_W'(rate);
      cfg_gated    = gated[0];
      cfg_interval = IVL_W'(ivl);
      cfg_channels = CH_W'(ch);
      cycle_tick   = with_tick;
      slot_free    = 1'b1;
      @(negedge clk);
      cfg_load   = 1'b0;
      cycle_tick = 1'b0;
      m_acc = 0; m_rate = rate; m_gated = gated; m_ivl = ivl; m_ch = ch;
   endtask

   // model: events the next commit should carry
   function automatic int model_events();
      int a;
      a = m_acc + m_rate;
      if (m_gated != 0) return ((a / 8000) >= m_ivl) ? m_ivl : 0;
      return a / 8000;
   endfunction

   // one strobe, outputs sampled on the following falling edge
   task automatic tick(input bit slot, input int lvl);
      @(negedge clk);
      cycle_tick = 1'b1;
      slot_free  = slot;
      buf_level  = LVL_W'(lvl);
      @(negedge clk);
      cycle_tick = 1'b0;
   endtask

   function automatic void model_commit(input int n);
      m_acc = m_acc + m_rate - n * 8000;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int total, n;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 valid", int'(pkt_valid), 0);
      check("R1 events", int'(pkt_events), 0);
      check("R1 quadlets", int'(pkt_quadlets), 0);
      rst_n = 1'b1;

      // vector table: R2 R3 R4 R5 R7 R8
      for (int v = 0; v < NVEC; v++) begin
         configure(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 1'b0);
         check((VEC[v][1] != 0) ? "R8 max_events" : "R2 max_events",
               int'(max_events), VEC[v][5]);
         total = 0;
         for (int t = 0; t < NTICK; t++) begin
            n = model_events();
            tick(1'b1, 4095);
            check("R10 valid", int'(pkt_valid), 1);
            check((VEC[v][1] != 0) ? "R4 events" : "R3 events", int'(pkt_events), n);
            check("R7 quadlets", int'(pkt_quadlets), n * VEC[v][3] + 2);
            model_commit(n);
            total += int'(pkt_events);
            @(negedge clk);
            check("R10 strobe", int'(pkt_valid), 0);
         end
         check("R5 total", total, VEC[v][4]);
      end

      // R6: busy slot holds state, retry yields the same count
      configure(48000, 0, 8, 2, 1'b0);
      tick(1'b0, 4095);
      check("R6 busy slot", int'(pkt_valid), 0);
      tick(1'b1, 4095);
      check("R6 retry valid", int'(pkt_valid), 1);
      check("R6 retry events", int'(pkt_events), 6);
      // R6: store one sample short, then exactly enough
      tick(1'b1, 11);
      check("R6 short store", int'(pkt_valid), 0);
      tick(1'b1, 12);
      check("R6 exact store", int'(pkt_valid), 1);
      check("R6 exact events", int'(pkt_events), 6);

      // R9: configuration coinciding with a strobe
      configure(44100, 0, 8, 2, 1'b0);
      tick(1'b1, 4095);
      check("R3 first 44k1", int'(pkt_events), 5);
      configure(44100, 0, 8, 2, 1'b1);
      check("R9 dropped tick", int'(pkt_valid), 0);
      tick(1'b1, 4095);
      check("R9 leftover cleared", int'(pkt_events), 5);

      // R4 R7: gated zero-event packet needs no samples
      configure(44100, 1, 8, 2, 1'b0);
      tick(1'b1, 0);
      check("R4 zero pkt valid", int'(pkt_valid), 1);
      check("R4 zero pkt events", int'(pkt_events), 0);
      check("R7 zero pkt quadlets", int'(pkt_quadlets), 2);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule